// File: doc/BRIEF.md
# Wormhole Switch Allocator and Crossbar

This block is the switching core of a five-port mesh router: four neighbour ports and one local port. Each input port presents a request vector naming the outputs it wants, and each output owns an arbiter that hands the output to one requesting input. Once an output is handed over, it stays with that input for the whole packet. The winner's flits go straight through a per-output multiplexer, and the output is freed only when the holder marks its last flit with end-of-packet.

Every output has its own round-robin pointer. After a packet finishes, the search for the next owner starts at the input just after the one that held the output, so every requester gets a turn. An output's multiplexer has legs for the four other ports only, so traffic can never be turned back to the port it came from. Route computation, flit buffering and link credits belong to the neighbouring blocks. Those blocks keep their request up until it is granted; the allocator stores no requests.

Top module: `wh_switch_alloc`

## Requirements
- R1: While reset is high and in the first cycle after it, every bit of `grant_o` is 0 and every flit output is all zeros. All round-robin pointers start at input 0.
- R2: Bit `req_i[i*5+o]` set means input i wants output o. If output o is free and not releasing, and some eligible input requests it at a clock edge, then from that edge on `grant_o[i*5+o]` is 1 for the chosen input i.
- R3: An output chooses among the eligible requesters by scanning upward from its pointer and wrapping from 4 to 0. When a packet ends, the pointer becomes the holder's index plus one, modulo 5.
- R4: A grant holds, whatever the holder's request does, until a clock edge at which `eop_i` of the holding input is 1. An `eop_i` from an input that holds no output has no effect.
- R5: The edge that sees the holder's end-of-packet clears the grant. The output stays unowned for that cycle and can be granted again at the following edge.
- R6: An input's request for its own port number is ignored and is never granted.
- R7: No input holds more than one output. An input that already holds an output (including one it is releasing) is not eligible. When free outputs contend for the same input at one edge, the lowest-numbered output takes it.
- R8: `flit_o[o]` equals `flit_i` of the input holding output o, with no register in the path. It is all zeros while output o is unowned.
- R9: Outputs work independently. Several outputs may grant different inputs at the same edge, and each output has at most one holder.
- R10: If inputs 0, 1, 2 and 4 request output 3 without pause, packets are granted in the strict order 0, 1, 2, 4, 0, ... and no requester waits more than three packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 25 | Request matrix; bit i*5+o means input i wants output o |
| eop_i | input | 5 | Bit i: input i is passing the last flit of its packet this cycle |
| flit_i | input | 5*FLIT_W | Flit of input i at bits i*FLIT_W upward |
| grant_o | output | 25 | Grant matrix; bit i*5+o means input i holds output o |
| flit_o | output | 5*FLIT_W | Flit of output o at bits o*FLIT_W upward |

## Verification
The vector table starts with a single output fought over by two inputs, with a self-request added. This separates correct pointer rotation and self-masking from a fixed-priority or unmasked choice. Later rows drop the holder's request in mid-packet and raise end-of-packet on inputs that hold nothing, which shows whether the lock is tied to the holder's end-of-packet alone. One row has an input asking for two free outputs at once while another input competes for one of them; this separates correct duplicate-grant avoidance from granting both. A directed run of back-to-back two-flit packets from four inputs to one output then checks the grant order, the one-cycle gap between packets, and that only the owner's flits appear on the output.

// File: rtl/wh_sa_pkg.sv
package wh_sa_pkg;

    localparam int PORTS = 5;
    localparam int IW    = $clog2(PORTS);

    typedef logic [IW-1:0] port_idx_t;

    typedef struct packed {
        logic      locked;
        port_idx_t owner;
        port_idx_t ptr;
    } out_state_t;

    typedef struct packed {
        logic      found;
        port_idx_t idx;
    } pick_t;

    function automatic port_idx_t wrap_inc(input port_idx_t p);
        return (p == port_idx_t'(PORTS - 1)) ? '0 : p + 1'b1;
    endfunction

    // first set bit of m at or after start, wrapping
    function automatic pick_t rr_pick(input logic [PORTS-1:0] m, input port_idx_t start);
        pick_t r;
        int    j;
        r = '0;
        for (int k = PORTS - 1; k >= 0; k--) begin
            j = int'(start) + k;
            if (j >= PORTS) j = j - PORTS;
            if (m[j]) begin
                r.found = 1'b1;
                r.idx   = port_idx_t'(j);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/wh_sa_out_port.sv
module wh_sa_out_port
    import wh_sa_pkg::*;
#(
    parameter int OUT_IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PORTS-1:0] req_col,
    input  logic [PORTS-1:0] avail,
    input  logic [PORTS-1:0] eop,
    output logic [PORTS-1:0] take,
    output logic [PORTS-1:0] grant_col,
    output out_state_t       st
);

    localparam logic [PORTS-1:0] ONE     = {{(PORTS-1){1'b0}}, 1'b1};
    localparam logic [PORTS-1:0] SELF_OH = ONE << OUT_IDX;

    logic [PORTS-1:0] elig;
    pick_t            pick;

    always_comb begin
        elig = req_col & avail & ~SELF_OH;
        pick = rr_pick(elig, st.ptr);
        take = (!st.locked && pick.found) ? (ONE << pick.idx) : '0;
        grant_col = st.locked ? (ONE << st.owner) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (st.locked) begin
            if (eop[st.owner]) begin
                st.locked <= 1'b0;
                st.ptr    <= wrap_inc(st.owner);
            end
        end else if (pick.found) begin
            st.locked <= 1'b1;
            st.owner  <= pick.idx;
        end
    end

endmodule

// File: rtl/wh_sa_out_mux.sv
module wh_sa_out_mux
    import wh_sa_pkg::*;
#(
    parameter int OUT_IDX = 0,
    parameter int FW      = 16
) (
    input  logic [PORTS*FW-1:0] flit_i,
    input  logic                locked,
    input  port_idx_t           owner,
    output logic [FW-1:0]       flit_o
);

    localparam int LEGS = PORTS - 1;
    localparam int SW   = $clog2(LEGS);

    logic [FW-1:0] leg [LEGS];
    logic [SW-1:0] sel;

    for (genvar k = 0; k < LEGS; k++) begin : g_leg
        localparam int SRC = (k < OUT_IDX) ? k : k + 1;
        assign leg[k] = flit_i[SRC*FW +: FW];
    end

    always_comb begin
        if (int'(owner) > OUT_IDX) sel = SW'(int'(owner) - 1);
        else                       sel = SW'(int'(owner));
        flit_o = locked ? leg[sel] : '0;
    end

endmodule

// File: rtl/wh_switch_alloc.sv
module wh_switch_alloc
    import wh_sa_pkg::*;
#(
    parameter int FLIT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PORTS*PORTS-1:0]  req_i,
    input  logic [PORTS-1:0]        eop_i,
    input  logic [PORTS*FLIT_W-1:0] flit_i,
    output logic [PORTS*PORTS-1:0]  grant_o,
    output logic [PORTS*FLIT_W-1:0] flit_o
);

    logic [PORTS-1:0] req_col   [PORTS];
    logic [PORTS-1:0] gcol      [PORTS];
    logic [PORTS-1:0] take      [PORTS];
    logic [PORTS-1:0] avail     [PORTS+1];
    out_state_t       st        [PORTS];
    logic [PORTS-1:0] busy_in;

    always_comb begin
        busy_in = '0;
        for (int o = 0; o < PORTS; o++) busy_in = busy_in | gcol[o];
    end

    assign avail[0] = ~busy_in;

    for (genvar o = 0; o < PORTS; o++) begin : g_out
        for (genvar i = 0; i < PORTS; i++) begin : g_in
            assign req_col[o][i]       = req_i[i*PORTS + o];
            assign grant_o[i*PORTS + o] = gcol[o][i];
        end

        assign avail[o+1] = avail[o] & ~take[o];

        wh_sa_out_port #(.OUT_IDX(o)) u_port (
            .clk       (clk),
            .rst       (rst),
            .req_col   (req_col[o]),
            .avail     (avail[o]),
            .eop       (eop_i),
            .take      (take[o]),
            .grant_col (gcol[o]),
            .st        (st[o])
        );

        wh_sa_out_mux #(.OUT_IDX(o), .FW(FLIT_W)) u_mux (
            .flit_i (flit_i),
            .locked (st[o].locked),
            .owner  (st[o].owner),
            .flit_o (flit_o[o*FLIT_W +: FLIT_W])
        );
    end

endmodule

// File: rtl/wh_switch_alloc_chk.sv
module wh_switch_alloc_chk
    import wh_sa_pkg::*;
#(
    parameter int FLIT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic [PORTS*PORTS-1:0]  req_i,
    input logic [PORTS-1:0]        eop_i,
    input logic [PORTS*FLIT_W-1:0] flit_i,
    input logic [PORTS*PORTS-1:0]  grant_o,
    input logic [PORTS*FLIT_W-1:0] flit_o
);

    for (genvar i = 0; i < PORTS; i++) begin : g_row
        p_one_out_r7: assert property (@(posedge clk) disable iff (rst)
            $onehot0(grant_o[i*PORTS +: PORTS]));

        p_self_masked_r6: assert property (@(posedge clk) disable iff (rst)
            !grant_o[i*PORTS + i]);
    end

    for (genvar o = 0; o < PORTS; o++) begin : g_col
        logic [PORTS-1:0] col;
        for (genvar i = 0; i < PORTS; i++) begin : g_b
            assign col[i] = grant_o[i*PORTS + o];
        end

        p_one_owner_r9: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col));

        p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
            (col == '0) |-> (flit_o[o*FLIT_W +: FLIT_W] == '0));

        for (genvar i = 0; i < PORTS; i++) begin : g_cell
            p_hold_r4: assert property (@(posedge clk) disable iff (rst)
                (grant_o[i*PORTS + o] && !eop_i[i]) |=> grant_o[i*PORTS + o]);

            p_release_r5: assert property (@(posedge clk) disable iff (rst)
                (grant_o[i*PORTS + o] && eop_i[i]) |=> !grant_o[i*PORTS + o]);

            p_req_first_r2: assert property (@(posedge clk) disable iff (rst)
                $rose(grant_o[i*PORTS + o]) |-> $past(req_i[i*PORTS + o]));

            p_flit_follow_r8: assert property (@(posedge clk) disable iff (rst)
                grant_o[i*PORTS + o] |->
                    (flit_o[o*FLIT_W +: FLIT_W] == flit_i[i*FLIT_W +: FLIT_W]));
        end
    end

endmodule

bind wh_switch_alloc wh_switch_alloc_chk #(.FLIT_W(FLIT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .eop_i   (eop_i),
    .flit_i  (flit_i),
    .grant_o (grant_o),
    .flit_o  (flit_o)
);

// File: tb/wh_switch_alloc_tb_top.sv
module wh_switch_alloc_tb_top;

    localparam int NP = 5;
    localparam int FW = 16;
    localparam int NV = 15;
    localparam logic [2:0] NO = 3'd7;

    logic            clk = 1'b0;
    logic            rst;
    logic [NP*NP-1:0] req;
    logic [NP-1:0]    eop;
    logic [NP*FW-1:0] flit;
    logic [NP*NP-1:0] grant;
    logic [NP*FW-1:0] fout;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] tag = 8'h00;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wh_switch_alloc #(.FLIT_W(FW)) dut_i (
        .clk (clk), .rst (rst), .req_i (req), .eop_i (eop),
        .flit_i (flit), .grant_o (grant), .flit_o (fout)
    );

    // per-output expected holder, 3 bits each, output 0 at the bottom, 7 = unowned
    localparam logic [NP*NP-1:0] VREQ [NV] = '{
        25'h0000421, 25'h0000400, 25'h0000400, 25'h0000420, 25'h0000420,
        25'h0000420, 25'h0000420, 25'h0430420, 25'h0400420, 25'h0430420,
        25'h0430420, 25'h0430420, 25'h020084A, 25'h0200842, 25'h0200842 };
    localparam logic [NP-1:0] VEOP [NV] = '{
        5'b00000, 5'b00000, 5'b00010, 5'b00000, 5'b00100,
        5'b00000, 5'b00110, 5'b00000, 5'b00000, 5'b01000,
        5'b00000, 5'b11100, 5'b00000, 5'b10001, 5'b00000 };
    localparam logic [3*NP-1:0] VEXP [NV] = '{
        {NO, NO, NO, NO, 3'd1},     // R2 R3 R6: self request of 0 masked, 1 wins
        {NO, NO, NO, NO, 3'd1},     // R4: holder drops request, lock stays
        {NO, NO, NO, NO, NO},       // R5: release on holder eop
        {NO, NO, NO, NO, 3'd2},     // R3: pointer moved past 1
        {NO, NO, NO, NO, NO},       // R5
        {NO, NO, NO, NO, 3'd1},     // R3: wrap 3,4,0 -> 1
        {NO, NO, NO, NO, NO},       // R4: eop of non-holder 2 ignored
        {NO, NO, 3'd4, 3'd3, 3'd2}, // R7 R9: input 3 to output 1 only
        {NO, NO, 3'd4, 3'd3, 3'd2}, // R4: holder 3 drops request
        {NO, NO, 3'd4, NO, 3'd2},   // R5
        {NO, NO, 3'd4, 3'd3, 3'd2}, // R5: regrant after one idle cycle
        {NO, NO, NO, NO, NO},       // R5 R9: three releases together
        {NO, 3'd0, NO, 3'd4, NO},   // R3 R9: pointer 4 picks 4, 0 goes to output 3
        {NO, NO, NO, NO, NO},       // R5
        {NO, NO, NO, 3'd0, NO}      // R3: pointer wrapped to 0
    };

    function automatic logic [NP*FW-1:0] make_flits(input logic [7:0] t);
        logic [NP*FW-1:0] f;
        for (int i = 0; i < NP; i++) f[i*FW +: FW] = {4'(i + 1), 4'h0, t};
        return f;
    endfunction

    task automatic check_owners(input logic [3*NP-1:0] exp, input string rq);
        logic [NP*NP-1:0] eg;
        logic [NP*FW-1:0] ef;
        eg = '0;
        ef = '0;
        for (int o = 0; o < NP; o++) begin
            if (exp[o*3 +: 3] != NO) begin
                eg[int'(exp[o*3 +: 3])*NP + o] = 1'b1;
                ef[o*FW +: FW] = flit[int'(exp[o*3 +: 3])*FW +: FW];
            end
        end
        checks++;
        if (grant !== eg || fout !== ef) begin
            fails++;
            $display("FAIL %s: grant=%h flit=%h expected grant=%h flit=%h",
                     rq, grant, fout, eg, ef);
        end
    endtask

    task automatic drive(input logic [NP*NP-1:0] r, input logic [NP-1:0] e);
        @(negedge clk);
        tag  = tag + 8'd1;
        req  = r;
        eop  = e;
        flit = make_flits(tag);
    endtask

    initial begin : watchdog
        #200000;
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [NP*NP-1:0] r3;
        int               expw;
        int               got;
        rst  = 1'b1;
        req  = '0;
        eop  = '0;
        flit = make_flits(8'h5A);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_owners({NO, NO, NO, NO, NO}, "R1 in reset");
        req = 25'h0000421;
        @(negedge clk);
        rst = 1'b0;
        check_owners({NO, NO, NO, NO, NO}, "R1 reset release");

        for (int v = 0; v < NV; v++) begin
            drive(VREQ[v], VEOP[v]);
            @(posedge clk);
            #1;
            check_owners(VEXP[v], $sformatf("R2-table row %0d", v));
        end

        // R10 R3 R5 R8: continuous contention on output 3
        drive('0, '0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        r3 = '0;
        r3[0*NP + 3] = 1'b1;
        r3[1*NP + 3] = 1'b1;
        r3[2*NP + 3] = 1'b1;
        r3[4*NP + 3] = 1'b1;
        drive(r3, '0);
        expw = 0;
        for (int p = 0; p < 12; p++) begin
            @(posedge clk);
            #1;
            got = -1;
            for (int i = 0; i < NP; i++) if (grant[i*NP + 3]) got = i;
            checks++;
            if (got != expw) begin
                fails++;
                $display("FAIL R10 packet %0d: holder=%0d expected=%0d", p, got, expw);
            end
            if (got < 0) got = expw;
            // first flit
            drive(r3, '0);
            @(posedge clk);
            #1;
            checks++;
            if (fout[3*FW +: FW] !== flit[got*FW +: FW]) begin
                fails++;
                $display("FAIL R8 packet %0d: flit=%h expected=%h", p, fout[3*FW +: FW], flit[got*FW +: FW]);
            end
            // last flit
            drive(r3, NP'(1) << got);
            @(posedge clk);
            #1;
            drive(r3, '0);
            checks++;
            if (grant !== '0 || fout !== '0) begin
                fails++;
                $display("FAIL R5 gap %0d: grant=%h flit=%h expected grant=0 flit=0", p, grant, fout);
            end
            expw = (got == 2) ? 4 : (got == 4 ? 0 : got + 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule